// File: doc/BRIEF.md
# Memory Tag Check Unit

This block sits in front of a memory port and checks each load or store whose 64-bit pointer carries a 4-bit key tag in its top byte. An internal lock store holds one 4-bit tag per aligned 16-byte granule. A tag-write port sets these locks. Software or an allocator model drives that port with a granule index and a tag. Every accepted request looks up the lock of its granule and compares it with the pointer's key. A request whose key matches goes to the downstream memory port unchanged.

A request whose key does not match is handled according to a mode pin. In synchronous mode the request is turned into an error response on a separate port and never reaches memory. In asynchronous mode the request still goes to memory, and the fault is recorded in a sticky status register. That register holds a flag and the address of the first faulting access. A global enable turns all checking off.

Both data-carrying interfaces use valid/ready handshakes:
- The request port accepts a beat in any cycle where `req_ready` is high.
- There is one register stage, so a result appears on exactly one of the two output ports in the cycle after acceptance.
- That result stays stable until its own port's ready is high.
- `req_ready` is low only when the stage is full and the port it is bound for is stalled.
- `chk_en` and `async_mode` are sampled in the cycle a request is accepted.

Top module: `tag_check_unit`

## Requirements
- R1: The key tag is `req_addr[59:56]`. The granule index is `req_addr[9:4]` for 64 granules. Bits [3:0], bits [63:60] and bits [55:10] do not affect which lock is used.
- R2: After reset every lock tag is 0, so a key-0 access passes and a nonzero key mismatches.
- R3: A tag written on the tag-write port is used by requests accepted in later cycles. A request accepted in the same cycle as a write to its granule is checked against the previous tag.
- R4: A matching access appears on the memory port one cycle after acceptance, with address, ID and store flag unchanged.
- R5: In synchronous mode (`async_mode`=0) a mismatching access is not forwarded. The error port instead presents its ID and full address.
- R6: In asynchronous mode (`async_mode`=1) a mismatching access is forwarded to memory. `st_fault` is set and `st_addr` holds its address.
- R7: Later faults leave `st_addr` unchanged while `st_fault` is set. A cycle with `st_clr`=1 clears the flag. A fault accepted in that same cycle is recorded as a new first fault.
- R8: With `chk_en`=0 every access is forwarded to memory and no fault is recorded.
- R9: Results leave in request order. A stalled output holds its contents stable, and the block accepts no new request while the stage is full and the selected port is not ready.
- R10: `mem_valid` and `err_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Global check enable |
| async_mode | input | 1 | 1 = record faults and continue, 0 = block and return an error |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_addr | input | 64 | Tagged pointer |
| req_id | input | 4 | Request identifier |
| req_store | input | 1 | 1 = store, 0 = load |
| mem_valid | output | 1 | Forwarded access valid |
| mem_ready | input | 1 | Downstream memory port ready |
| mem_addr | output | 64 | Forwarded address |
| mem_id | output | 4 | Forwarded identifier |
| mem_store | output | 1 | Forwarded store flag |
| err_valid | output | 1 | Synchronous fault response valid |
| err_ready | input | 1 | Fault response consumer ready |
| err_addr | output | 64 | Faulting address |
| err_id | output | 4 | Faulting request identifier |
| tw_valid | input | 1 | Tag write strobe |
| tw_gran | input | 6 | Granule index to write |
| tw_tag | input | 4 | Lock tag value |
| st_clr | input | 1 | Write-1 clear of the sticky fault record |
| st_fault | output | 1 | Sticky asynchronous fault flag |
| st_addr | output | 64 | Address of the first recorded fault |

## Verification
The hardest case to reach from the ports is a request accepted in the same edge as a tag write to its own granule. The request must not stall that cycle, or the write lands first. The bench therefore turns back-pressure off and drives both strobes in one cycle, expecting the old tag. A fault arriving in the same cycle as a status clear is produced the same way, with `st_clr` held through the accepting cycle. Ordering under stalls is covered by a long stream of back-to-back requests with random ready on both output ports and mixed match and mismatch keys.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int unsigned KEY_W   = 4;
  localparam int unsigned KEY_LSB = 56;
  localparam int unsigned GRAN_LSB = 4;

  typedef enum logic {
    ROUTE_MEM = 1'b0,
    ROUTE_ERR = 1'b1
  } route_e;
endpackage

// File: rtl/tcu_tag_store.sv
module tcu_tag_store #(
  parameter int unsigned GRANULES = 64,
  parameter int unsigned TAG_W    = 4,
  localparam int unsigned IDX_W   = $clog2(GRANULES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag
);
  logic [TAG_W-1:0] lock_q [GRANULES];

  // one register per granule; a same-edge read sees the value before the write
  for (genvar g = 0; g < GRANULES; g++) begin : g_lock
    always_ff @(posedge clk) begin
      if (!rst_n)
        lock_q[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))
        lock_q[g] <= wr_tag;
    end
  end

  assign rd_tag = lock_q[rd_idx];
endmodule

// File: rtl/tcu_fault_log.sv
module tcu_fault_log #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_addr,
  output logic              flag,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      addr <= '0;
    end else if (hit && (clr || !flag)) begin
      flag <= 1'b1;
      addr <= hit_addr;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

  // R7
  sticky_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag && $stable(addr));

  // R7
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !hit |=> !flag);
endmodule

// File: rtl/tag_check_unit.sv
module tag_check_unit #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned ID_W     = 4,
  parameter int unsigned GRANULES = 64,
  localparam int unsigned IDX_W   = $clog2(GRANULES),
  localparam int unsigned TAG_W   = tcu_pkg::KEY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic              async_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   req_id,
  input  logic              req_store,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ID_W-1:0]   mem_id,
  output logic              mem_store,
  output logic              err_valid,
  input  logic              err_ready,
  output logic [ADDR_W-1:0] err_addr,
  output logic [ID_W-1:0]   err_id,
  input  logic              tw_valid,
  input  logic [IDX_W-1:0]  tw_gran,
  input  logic [TAG_W-1:0]  tw_tag,
  input  logic              st_clr,
  output logic              st_fault,
  output logic [ADDR_W-1:0] st_addr
);
  import tcu_pkg::*;

  logic [TAG_W-1:0]  key, lock;
  logic [IDX_W-1:0]  gran;
  logic              mismatch, accept, drain;
  logic              full_q;
  route_e            route_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ID_W-1:0]   id_q;
  logic              store_q;

  assign key  = req_addr[KEY_LSB +: TAG_W];
  assign gran = req_addr[GRAN_LSB +: IDX_W];

  tcu_tag_store #(.GRANULES(GRANULES), .TAG_W(TAG_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tw_valid),
    .wr_idx (tw_gran),
    .wr_tag (tw_tag),
    .rd_idx (gran),
    .rd_tag (lock)
  );

  assign mismatch  = chk_en && (key != lock);
  assign drain     = full_q && ((route_q == ROUTE_ERR) ? err_ready : mem_ready);
  assign req_ready = !full_q || drain;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      route_q <= ROUTE_MEM;
      addr_q  <= '0;
      id_q    <= '0;
      store_q <= 1'b0;
    end else if (accept) begin
      full_q  <= 1'b1;
      route_q <= (mismatch && !async_mode) ? ROUTE_ERR : ROUTE_MEM;
      addr_q  <= req_addr;
      id_q    <= req_id;
      store_q <= req_store;
    end else if (drain) begin
      full_q  <= 1'b0;
    end
  end

  assign mem_valid = full_q && (route_q == ROUTE_MEM);
  assign err_valid = full_q && (route_q == ROUTE_ERR);
  assign mem_addr  = addr_q;
  assign mem_id    = id_q;
  assign mem_store = store_q;
  assign err_addr  = addr_q;
  assign err_id    = id_q;

  tcu_fault_log #(.ADDR_W(ADDR_W)) u_log (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (st_clr),
    .hit      (accept && mismatch && async_mode),
    .hit_addr (req_addr),
    .flag     (st_fault),
    .addr     (st_addr)
  );

  // R10
  one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && err_valid));

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_id));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && !err_ready |=> err_valid && $stable(err_addr) && $stable(err_id));

  // R4
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_valid || err_valid);

  // R8
  off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !chk_en |=> mem_valid);
endmodule

// File: tb/tag_check_unit_test.sv
`timescale 1ns/1ps
module tag_check_unit_test;
  localparam int IDX_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chk_en = 1'b0, async_mode = 1'b0;
  logic req_valid = 1'b0, req_ready, req_store = 1'b0;
  logic [63:0] req_addr = '0;
  logic [3:0] req_id = '0;
  logic mem_valid, mem_ready = 1'b1, mem_store;
  logic [63:0] mem_addr, err_addr, st_addr;
  logic [3:0] mem_id, err_id;
  logic err_valid, err_ready = 1'b1;
  logic tw_valid = 1'b0;
  logic [IDX_W-1:0] tw_gran = '0;
  logic [3:0] tw_tag = '0;
  logic st_clr = 1'b0, st_fault;

  int checks = 0, errors = 0;
  bit bp_on = 1'b0;
  logic [3:0] model [64];

  typedef struct { bit is_err; logic [63:0] addr; logic [3:0] id; bit store; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  tag_check_unit uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ready generator: changes only at negedge
  initial forever begin
    @(negedge clk);
    mem_ready = bp_on ? ($urandom % 4 != 0) : 1'b1;
    err_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
  end

  // driver: computes expectation in the accepting cycle from the bench tag model
  task automatic send(input logic [63:0] a, input logic [3:0] id, input bit st,
                      input bit tw = 0, input logic [5:0] tg = 0, input logic [3:0] tt = 0,
                      input bit clr = 0);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_id = id; req_store = st;
    tw_valid = tw; tw_gran = tg; tw_tag = tt; st_clr = clr;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    e.is_err = chk_en && !async_mode && (a[59:56] != model[a[9:4]]);
    e.addr = a; e.id = id; e.store = st;
    sb.push_back(e);
    @(posedge clk);
    if (tw) model[tg] = tt;
    #1;
    req_valid = 1'b0; tw_valid = 1'b0; st_clr = 1'b0;
  endtask

  task automatic tag_write(input logic [5:0] g, input logic [3:0] t);
    @(negedge clk);
    tw_valid = 1'b1; tw_gran = g; tw_tag = t;
    @(posedge clk);
    model[g] = t;
    #1 tw_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [63:0] mk(input logic [3:0] key, input logic [5:0] g);
    return {4'h0, key, 46'h0, g, 4'h0};
  endfunction

  // monitor: samples 1.5 ns after negedge, before the next posedge
  initial begin
    bit pm = 0, pe = 0;
    logic [63:0] pa = '0;
    forever begin
      @(negedge clk); #1.5;
      if (rst_n) begin
        if (pm) check(mem_valid && mem_addr == pa, "R9", "stalled mem output changed", mem_addr, pa);
        if (pe) check(err_valid && err_addr == pa, "R9", "stalled err output changed", err_addr, pa);
        if (mem_valid && mem_ready) begin
          exp_t e;
          if (sb.size() == 0) check(0, "R9", "unexpected mem beat", mem_addr, 0);
          else begin
            e = sb.pop_front();
            check(!e.is_err, "R5", "route mem vs err", 0, 1);
            check(mem_addr == e.addr && mem_id == e.id && mem_store == e.store,
                  "R4", "mem beat addr", mem_addr, e.addr);
          end
        end
        if (err_valid && err_ready) begin
          exp_t e;
          if (sb.size() == 0) check(0, "R9", "unexpected err beat", err_addr, 0);
          else begin
            e = sb.pop_front();
            check(e.is_err, "R5", "route err vs mem", 1, 0);
            check(err_addr == e.addr && err_id == e.id, "R5", "err beat addr", err_addr, e.addr);
          end
        end
        pm = mem_valid && !mem_ready; pe = err_valid && !err_ready;
        pa = mem_valid ? mem_addr : err_addr;
      end
    end
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 4'h0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R2 reset state at the ports
    check(req_ready && !mem_valid && !err_valid && !st_fault, "R2", "reset outputs",
          {mem_valid, err_valid, st_fault}, 0);

    chk_en = 1'b1; async_mode = 1'b0;
    send(mk(4'h0, 6'd5), 4'd1, 0);           // R2 key 0 passes
    send(mk(4'h3, 6'd5), 4'd2, 1);           // R2 nonzero key faults
    tag_write(6'd5, 4'h3);
    send(mk(4'h3, 6'd5), 4'd3, 0);           // R3 new tag used
    send(mk(4'h0, 6'd5), 4'd4, 0);           // R3 old key now faults
    send({4'hA, 4'h3, 46'h2BCD_1234_5678, 6'd5, 4'hF}, 4'd5, 1); // R1 other bits ignored
    send({4'h5, 4'h3, 46'h0, 6'd6, 4'h0}, 4'd6, 0);              // R1 neighbour granule differs
    send(mk(4'h7, 6'd9), 4'd7, 0, 1, 6'd9, 4'h7); // R3 same-cycle write: old tag
    send(mk(4'h7, 6'd9), 4'd8, 0);           // R3 then new tag applies
    idle(3);

    chk_en = 1'b0;                           // R8
    send(mk(4'hE, 6'd20), 4'd9, 0);
    send(mk(4'h1, 6'd21), 4'd10, 1);
    async_mode = 1'b1;
    send(mk(4'h2, 6'd22), 4'd11, 0);
    idle(3);
    check(!st_fault, "R8", "fault recorded while disabled", st_fault, 0);

    chk_en = 1'b1;                           // R6 / R7
    send(mk(4'h4, 6'd30), 4'd12, 0);
    send(mk(4'h8, 6'd31), 4'd13, 1);
    idle(3);
    check(st_fault, "R6", "async flag", st_fault, 1);
    check(st_addr == mk(4'h4, 6'd30), "R7", "first fault address kept", st_addr, mk(4'h4, 6'd30));
    @(negedge clk); st_clr = 1'b1; @(negedge clk); st_clr = 1'b0; #1;
    check(!st_fault, "R7", "clear", st_fault, 0);
    send(mk(4'h9, 6'd33), 4'd14, 0);
    idle(2);
    send(mk(4'hB, 6'd34), 4'd15, 0, 0, 0, 0, 1); // R7 fault with clear same cycle
    idle(3);
    check(st_fault && st_addr == mk(4'hB, 6'd34), "R7", "fault on clear cycle", st_addr, mk(4'hB, 6'd34));
    async_mode = 1'b0;

    bp_on = 1'b1;                            // R9 ordered stream under stalls
    for (int n = 0; n < 400; n++) begin
      logic [63:0] a;
      a = {$urandom, $urandom};
      a[59:56] = ($urandom % 2) ? model[a[9:4]] : 4'($urandom);
      send(a, 4'(n), 1'($urandom));
      if (n % 50 == 49) tag_write(6'($urandom), 4'($urandom));
    end
    bp_on = 1'b0;
    idle(10);
    check(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule